// File: doc/BRIEF.md
# Rotating Single-LED Chaser

This block drives a row of LEDs so that only one of them is lit at any moment. At a fixed interval the lit position moves one place toward bit 0. After bit 0 it jumps back to the top bit. It is a free-running display pattern. There is no software control. The block needs only a clock and a synchronous reset.

A prescaler counter divides the system clock down to a one-cycle step pulse. The interval is set through two parameters: the clock frequency and the step period in milliseconds. With the defaults of 50 MHz and 500 ms, the step comes every 25,000,000 cycles. The lit position is held in a one-hot ring register.

The LEDs are wired common-anode, so an LED lights when its pin is low. The output stage therefore drives the inverse of the one-hot position. A parameter selects the other polarity for boards wired the opposite way.

Top module: `led_chaser`

## Requirements
- R1: While reset is asserted and on the first cycle after it, only the top LED (bit LED_COUNT-1) is lit. With 8 LEDs active-low, `led_n` is 8'h7F.
- R2: The lit position changes exactly once every STEP_CYCLES clock cycles and holds its value in between. STEP_CYCLES is CLK_HZ/1000*STEP_MS.
- R3: Each step moves the lit position from bit k to bit k-1.
- R4: The step after bit 0 is lit lights the top bit again (wrap from 8'hFE to 8'h7F for 8 active-low LEDs).
- R5: Outside reset, exactly one LED is lit on every cycle.
- R6: With the default active-low polarity, a lit LED drives a 0 on its `led_n` bit and every unlit LED drives a 1.
- R7: A reset asserted in the middle of a run clears the prescaler. The first step after release comes a full STEP_CYCLES cycles later, not sooner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| led_n | output | LED_COUNT | LED pins, one lit; 0 lights an LED in active-low polarity |

## Verification
The bench builds the block with CLK_HZ=5000 and STEP_MS=1, so one step takes only 5 clock cycles. With that setting a full circuit of all eight positions and several wraps fit into a few hundred cycles. This makes it possible to compare every cycle of the run against an expected pattern computed from the cycle count. The short period also puts a mid-run reset, and the complete interval that must follow it, within a handful of cycles. The defaults are kept, with 8 LEDs and active-low drive.

// File: rtl/chase_pkg.sv
package chase_pkg;

   // Electrical sense of the LED pins.
   typedef enum logic {
      POL_ACTIVE_HIGH = 1'b0,
      POL_ACTIVE_LOW  = 1'b1
   } led_pol_e;

endpackage

// File: rtl/chase_prescaler.sv
module chase_prescaler #(
   parameter int unsigned PERIOD = 25_000_000
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   if (PERIOD < 2) begin : g_bad_period
      $error("chase_prescaler: PERIOD must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (cnt_q == LAST)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == LAST);

endmodule

// File: rtl/chase_ring.sv
module chase_ring #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   output logic [WIDTH-1:0] pos
);
   localparam logic [WIDTH-1:0] HOME = {1'b1, {(WIDTH-1){1'b0}}};

   if (WIDTH < 2) begin : g_bad_width
      $error("chase_ring: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] pos_q;

   always_ff @(posedge clk) begin
      if (rst)
         pos_q <= HOME;
      else if (step)
         pos_q <= {pos_q[0], pos_q[WIDTH-1:1]};
   end

   assign pos = pos_q;

endmodule

// File: rtl/chase_drive.sv
module chase_drive
   import chase_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter led_pol_e    POL   = POL_ACTIVE_LOW
) (
   input  logic [WIDTH-1:0] lit,
   output logic [WIDTH-1:0] pins
);
   if (POL == POL_ACTIVE_LOW) begin : g_sink
      assign pins = ~lit;
   end else begin : g_source
      assign pins = lit;
   end

endmodule

// File: rtl/led_chaser.sv
module led_chaser
   import chase_pkg::*;
#(
   parameter int unsigned CLK_HZ    = 50_000_000,
   parameter int unsigned STEP_MS   = 500,
   parameter int unsigned LED_COUNT = 8,
   parameter led_pol_e    POL       = POL_ACTIVE_LOW
) (
   input  logic                 clk,
   input  logic                 rst,
   output logic [LED_COUNT-1:0] led_n
);
   localparam int unsigned STEP_CYCLES = CLK_HZ / 1000 * STEP_MS;

   if (CLK_HZ < 1000) begin : g_bad_clk
      $error("led_chaser: CLK_HZ must be at least 1000");
   end
   if (STEP_CYCLES < 2) begin : g_bad_step
      $error("led_chaser: step interval must span at least 2 cycles");
   end

   logic                 step_tick;
   logic [LED_COUNT-1:0] lit_pos;

   chase_prescaler #(.PERIOD(STEP_CYCLES)) u_prescale (
      .clk  (clk),
      .rst  (rst),
      .tick (step_tick)
   );

   chase_ring #(.WIDTH(LED_COUNT)) u_ring (
      .clk  (clk),
      .rst  (rst),
      .step (step_tick),
      .pos  (lit_pos)
   );

   chase_drive #(.WIDTH(LED_COUNT), .POL(POL)) u_drive (
      .lit  (lit_pos),
      .pins (led_n)
   );

endmodule

// File: rtl/led_chaser_chk.sv
module led_chaser_chk #(
   parameter int unsigned WIDTH      = 8,
   parameter int unsigned PERIOD     = 25_000_000,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             tick,
   input logic [WIDTH-1:0] led_n
);
   localparam int unsigned GW = $clog2(PERIOD + 1);
   localparam logic [WIDTH-1:0] TOP = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH-1:0] lit;
   logic [GW-1:0]    since_tick;

   assign lit = ACTIVE_LOW ? ~led_n : led_n;

   always_ff @(posedge clk) begin
      if (rst || tick)
         since_tick <= '0;
      else
         since_tick <= since_tick + 1'b1;
   end

   AST_HOME_AFTER_RESET: assert property (@(posedge clk) rst |=> lit == TOP);                          // R1
   AST_HOLD_BETWEEN:     assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(led_n));  // R2
   AST_TICK_PERIOD:      assert property (@(posedge clk) disable iff (rst) tick |-> since_tick == GW'(PERIOD - 1)); // R2
   AST_SHIFT_DOWN:       assert property (@(posedge clk) disable iff (rst) (tick && !lit[0]) |=> lit == ($past(lit) >> 1)); // R3
   AST_WRAP_TOP:         assert property (@(posedge clk) disable iff (rst) (tick && lit[0]) |=> lit == TOP); // R4
   AST_ONE_LIT:          assert property (@(posedge clk) disable iff (rst) $countones(lit) == 1);      // R5

endmodule

bind led_chaser led_chaser_chk #(
   .WIDTH      (LED_COUNT),
   .PERIOD     (STEP_CYCLES),
   .ACTIVE_LOW (POL == chase_pkg::POL_ACTIVE_LOW)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .tick  (step_tick),
   .led_n (led_n)
);

// File: tb/led_chaser_tb_top.sv
module led_chaser_tb_top;
   localparam int N = 5;  // CLK_HZ=5000, STEP_MS=1

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] led_n;

   int checks   = 0;
   int failures = 0;
   int j        = 0;   // posedges since reset release
   bit finished = 1'b0;

   always #5 clk = ~clk;

   led_chaser #(.CLK_HZ(5000), .STEP_MS(1)) dut_i (
      .clk   (clk),
      .rst   (rst),
      .led_n (led_n)
   );

   function automatic logic [7:0] exp_led(int cyc);
      int idx = 7 - ((cyc / N) % 8);
      return ~(8'b1 << idx);
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] expv);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s: led_n=%h expected %h (cycle %0d)", req, act, expv, j);
      end
   endtask

   task automatic hold_reset(int edges);
      @(negedge clk) rst = 1'b1;
      for (int i = 0; i < edges; i++) @(negedge clk);
      check("R1", led_n, 8'h7F);
      rst = 1'b0;
      j = 0;
   endtask

   // advance one edge, sample at the following negedge
   task automatic step_and_check(string req);
      @(negedge clk);
      j++;
      check(req, led_n, exp_led(j));
      checks++;
      if ($countones(~led_n) != 1) begin
         failures++;
         $display("FAIL R5: led_n=%h expected one zero bit", led_n);
      end
   endtask

   task automatic t_reset_state();
      hold_reset(2);
      check("R6", led_n, 8'b0111_1111);
      for (int i = 0; i < N - 1; i++) step_and_check("R1");
      check("R1", led_n, 8'h7F);
   endtask

   task automatic t_first_steps();
      hold_reset(1);
      for (int i = 0; i < 3 * N; i++) step_and_check("R2");
      check("R3", led_n, 8'hEF);
   endtask

   task automatic t_wrap();
      hold_reset(1);
      for (int i = 0; i < 8 * N - 1; i++) step_and_check("R3");
      check("R6", led_n, 8'hFE);
      step_and_check("R4");
      check("R4", led_n, 8'h7F);
      for (int i = 0; i < 2 * N; i++) step_and_check("R4");
   endtask

   task automatic t_midrun_reset();
      hold_reset(1);
      for (int i = 0; i < 2 * N + 2; i++) step_and_check("R3");
      hold_reset(1);
      for (int i = 0; i < N - 1; i++) step_and_check("R7");
      check("R7", led_n, 8'h7F);
      step_and_check("R7");
      check("R7", led_n, 8'hBF);
   endtask

   task automatic t_long_run();
      hold_reset(1);
      for (int i = 0; i < 20 * N; i++) step_and_check("R5");
   endtask

   initial begin
      t_reset_state();
      t_first_steps();
      t_wrap();
      t_midrun_reset();
      t_long_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule